// File: doc/BRIEF.md
# I2S Transmit Serializer

The block turns audio samples held in a small transmit queue into a master-mode serial stream made of a bit clock, a word-select line and a data line. Software-side logic writes 32-bit words, or 16-bit upper-half words for the 48-bit packed layout, into an 8-entry queue. The serializer takes one or two entries at each frame boundary, splits them into a left and a right sample according to the programmed sample width, and shifts each sample out MSB first at a programmed position inside its half of the frame.

Sample width, frame length and bit-clock divider are each programmed as the value minus one. Mono mode, channel swap, clock and word-select inversion, and zero fill on underrun are individual configuration inputs. A level interrupt reports a queue at or below its watermark. A sticky underrun flag records any frame start that found too few entries.

Top module: `i2s_tx_serializer`

## Requirements
- R1: The queue holds 8 entries. `full_o` is high while 8 entries are held, and a write arriving while full is discarded. `wr_i` pushes `wr_data_i`, `wr_hi_i` pushes `{16'h0, wr_hi_data_i}`, and only one of the two is asserted in a given cycle.
- R2: While enabled, the internal bit clock stays low for `cfg_div_m1_i+1` system clocks and then high for `cfg_div_m1_i+1` system clocks. `sck_o` is this internal clock XOR `cfg_sck_inv_i`.
- R3: A frame lasts F = `cfg_frame_m1_i+1` bit periods, numbered slot 0 to F-1, with H = floor(F/2). The internal word select is 0 in slots below H and 1 from slot H on. `ws_o` is this value XOR `cfg_ws_inv_i`.
- R4: With L = `cfg_len_m1_i+1` and P = `cfg_pos_i`, the sample of the first half is driven MSB first in slots P+1 to P+L, and the sample of the second half in slots H+P+1 to H+P+L. `sd_o` is 0 in every other slot.
- R5: For L up to 16 in stereo, one entry makes a pair: left is bits [15:0] and right is bits [31:16], each using its low L bits. This gives bits 3:0 and 19:16 at L=4, and bits 7:0 and 23:16 at L=8.
- R6: For L of 17 to 32 in stereo, a pair uses two entries taken in order. Without packing, or with L above 24, left is the first entry and right is the second. With `cfg_pack48_i` and L of 17 to 24, left is first[23:0] and right is {second[15:0], first[31:24]}.
- R7: In mono mode one entry is taken per frame. Its low L bits form the first-channel sample, and the other channel's slots carry 0. The packing option has no effect in mono mode.
- R8: With `cfg_swap_i` set, the right (or mono-empty) sample goes in the half where the internal word select is 0, and the left sample goes in the other half.
- R9: Entries are fetched in the first enabled cycle and in the cycle where the last slot of a frame ends. A frame's samples come only from that fetch.
- R10: A fetch that finds fewer entries than the format needs takes none and sets `underrun_o`. The frame then sends zeros if `cfg_zero_fill_i` is set, and repeats the previous samples otherwise.
- R11: `underrun_o` is sticky. `err_clr_i` clears it, and a new underrun in the same cycle takes priority over the clear.
- R12: `lvl_irq_o` is high while the queue level is at or below `cfg_wmark_i`. A watermark of 0 therefore signals an empty queue.
- R13: While `en_i` is low, the counters rest at slot 0. In that state `sd_o` is 0, the internal bit clock and word select are 0, and the queue keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run the serializer |
| wr_i | input | 1 | Push a 32-bit word |
| wr_data_i | input | 32 | Word to push |
| wr_hi_i | input | 1 | Push a 16-bit upper-half word |
| wr_hi_data_i | input | 16 | Upper-half word to push |
| cfg_len_m1_i | input | 5 | Sample width minus one |
| cfg_frame_m1_i | input | FRM_W (9) | Frame length in bits minus one |
| cfg_div_m1_i | input | DIV_W (8) | Bit-clock half period in system clocks, minus one |
| cfg_pos_i | input | FRM_W (9) | Data offset within each half frame |
| cfg_mono_i | input | 1 | One sample per frame |
| cfg_pack48_i | input | 1 | 48-bit pair layout for 17 to 24 bit samples |
| cfg_swap_i | input | 1 | Send the right sample while word select is low |
| cfg_sck_inv_i | input | 1 | Invert the bit clock |
| cfg_ws_inv_i | input | 1 | Invert the word select |
| cfg_zero_fill_i | input | 1 | Send zeros after an underrun |
| cfg_wmark_i | input | WM_W (3) | Level interrupt watermark |
| err_clr_i | input | 1 | Clear the underrun flag |
| sck_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select |
| sd_o | output | 1 | Serial data |
| lvl_irq_o | output | 1 | Queue at or below watermark |
| underrun_o | output | 1 | Sticky underrun flag |
| full_o | output | 1 | Queue full |

## Verification
The assertions assume that `wr_i` and `wr_hi_i` are never high together, and that the watermark width keeps it below the queue depth. Both properties then bound the level: a full queue never reports its interrupt, and it stays full unless a fetch pops. They also assume that configuration changes happen only while the serializer is disabled, and that every frame satisfies P+L+1 <= H. The stimulus changes configuration only with `en_i` low, pushes through exactly one write port per cycle, and picks frame length, width and position in each phase so that the windows fit. A behavioural model with a queue and integer counters predicts every output on every clock.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned LEN_W  = 5;

  typedef enum logic [1:0] {
    FMT_HALF = 2'd0,  // both channels in one entry
    FMT_TWO  = 2'd1,  // one entry per channel
    FMT_PACK = 2'd2,  // 48-bit pair over two entries
    FMT_MONO = 2'd3   // one entry, one channel
  } fetch_fmt_e;

  function automatic fetch_fmt_e pick_fmt(input logic [LEN_W-1:0] len_m1,
                                          input logic mono, input logic pack48);
    if (mono) return FMT_MONO;
    if (len_m1 < LEN_W'(16)) return FMT_HALF;
    if (pack48 && len_m1 < LEN_W'(24)) return FMT_PACK;
    return FMT_TWO;
  endfunction

  function automatic logic needs_pair(input fetch_fmt_e f);
    return (f == FMT_TWO) || (f == FMT_PACK);
  endfunction
endpackage

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [DW-1:0]    push_data_i,
  input  logic             pop_i,
  input  logic             pop_pair_i,
  output logic [DW-1:0]    head0_o,
  output logic [DW-1:0]    head1_o,
  output logic [LVL_W-1:0] level_o,
  output logic             full_o
);
  logic [DW-1:0]    mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0] level_q, pop_n;
  logic             accept;

  assign full_o  = (level_q == LVL_W'(DEPTH));
  assign accept  = push_i && !full_o;
  assign pop_n   = pop_i ? (pop_pair_i ? LVL_W'(2) : LVL_W'(1)) : '0;
  assign head0_o = mem_q[rd_ptr_q];
  assign head1_o = mem_q[rd_ptr_q + AW'(1)];
  assign level_o = level_q;

  always_ff @(posedge clk_i) begin
    if (accept) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (accept) wr_ptr_q <= wr_ptr_q + AW'(1);
      rd_ptr_q <= rd_ptr_q + AW'(pop_n);
      level_q  <= level_q + LVL_W'(accept) - pop_n;
    end
  end
endmodule

// File: rtl/i2s_tx_unpack.sv
module i2s_tx_unpack
  import i2s_tx_pkg::*;
(
  input  fetch_fmt_e        fmt_i,
  input  logic [WORD_W-1:0] e0_i,
  input  logic [WORD_W-1:0] e1_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o
);
  always_comb begin
    unique case (fmt_i)
      FMT_HALF: begin
        left_o  = {{HALF_W{1'b0}}, e0_i[HALF_W-1:0]};
        right_o = {{HALF_W{1'b0}}, e0_i[WORD_W-1:HALF_W]};
      end
      FMT_PACK: begin
        left_o  = {8'h00, e0_i[23:0]};
        right_o = {8'h00, e1_i[15:0], e0_i[31:24]};
      end
      FMT_MONO: begin
        left_o  = e0_i;
        right_o = '0;
      end
      default: begin
        left_o  = e0_i;
        right_o = e1_i;
      end
    endcase
  end
endmodule

// File: rtl/i2s_tx_clkgen.sv
module i2s_tx_clkgen #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned FRM_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_m1_i,
  input  logic [FRM_W-1:0] frame_m1_i,
  output logic             run_o,
  output logic             phase_o,
  output logic [FRM_W-1:0] slot_o,
  output logic             load_o
);
  logic             run_q, phase_q;
  logic [DIV_W-1:0] div_cnt_q;
  logic [FRM_W-1:0] slot_q;
  logic             half_end, frame_end;

  assign half_end  = (div_cnt_q == div_m1_i);
  assign frame_end = run_q && half_end && phase_q && (slot_q >= frame_m1_i);
  assign load_o    = en_i && (!run_q || frame_end);
  assign run_o     = run_q;
  assign phase_o   = phase_q;
  assign slot_o    = slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      phase_q   <= 1'b0;
      div_cnt_q <= '0;
      slot_q    <= '0;
    end else if (!en_i) begin
      run_q     <= 1'b0;
      phase_q   <= 1'b0;
      div_cnt_q <= '0;
      slot_q    <= '0;
    end else if (!run_q) begin
      run_q <= 1'b1;
    end else if (half_end) begin
      div_cnt_q <= '0;
      phase_q   <= ~phase_q;
      if (phase_q) slot_q <= (slot_q >= frame_m1_i) ? '0 : slot_q + FRM_W'(1);
    end else begin
      div_cnt_q <= div_cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
  import i2s_tx_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DIV_W = 8,
  parameter int unsigned FRM_W = 9,
  localparam int unsigned WM_W  = $clog2(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              wr_hi_i,
  input  logic [HALF_W-1:0] wr_hi_data_i,
  input  logic [LEN_W-1:0]  cfg_len_m1_i,
  input  logic [FRM_W-1:0]  cfg_frame_m1_i,
  input  logic [DIV_W-1:0]  cfg_div_m1_i,
  input  logic [FRM_W-1:0]  cfg_pos_i,
  input  logic              cfg_mono_i,
  input  logic              cfg_pack48_i,
  input  logic              cfg_swap_i,
  input  logic              cfg_sck_inv_i,
  input  logic              cfg_ws_inv_i,
  input  logic              cfg_zero_fill_i,
  input  logic [WM_W-1:0]   cfg_wmark_i,
  input  logic              err_clr_i,
  output logic              sck_o,
  output logic              ws_o,
  output logic              sd_o,
  output logic              lvl_irq_o,
  output logic              underrun_o,
  output logic              full_o
);
  localparam int unsigned CW = FRM_W + 2;

  fetch_fmt_e        fmt;
  logic              pair, avail, load_fire, pop_fire, err_set, err_q;
  logic [LVL_W-1:0]  fifo_level;
  logic [WORD_W-1:0] head0, head1, unp_left, unp_right;
  logic [WORD_W-1:0] left_q, right_q, first_smp, second_smp;
  logic              run, phase;
  logic [FRM_W-1:0]  slot;
  logic              push;
  logic [WORD_W-1:0] push_data;

  // one write port per cycle; the full word wins
  assign push      = wr_i || wr_hi_i;
  assign push_data = wr_i ? wr_data_i : {{(WORD_W-HALF_W){1'b0}}, wr_hi_data_i};

  assign fmt      = pick_fmt(cfg_len_m1_i, cfg_mono_i, cfg_pack48_i);
  assign pair     = needs_pair(fmt);
  assign avail    = pair ? (fifo_level >= LVL_W'(2)) : (fifo_level >= LVL_W'(1));
  assign pop_fire = load_fire && avail;
  assign err_set  = load_fire && !avail;

  i2s_tx_fifo #(.DEPTH(DEPTH), .DW(WORD_W)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (pop_fire),
    .pop_pair_i  (pair),
    .head0_o     (head0),
    .head1_o     (head1),
    .level_o     (fifo_level),
    .full_o      (full_o)
  );

  i2s_tx_unpack u_unpack (
    .fmt_i   (fmt),
    .e0_i    (head0),
    .e1_i    (head1),
    .left_o  (unp_left),
    .right_o (unp_right)
  );

  i2s_tx_clkgen #(.DIV_W(DIV_W), .FRM_W(FRM_W)) u_clkgen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .div_m1_i   (cfg_div_m1_i),
    .frame_m1_i (cfg_frame_m1_i),
    .run_o      (run),
    .phase_o    (phase),
    .slot_o     (slot),
    .load_o     (load_fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q  <= '0;
      right_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (pop_fire) begin
        left_q  <= unp_left;
        right_q <= unp_right;
      end else if (err_set && cfg_zero_fill_i) begin
        left_q  <= '0;
        right_q <= '0;
      end
      if (err_set)        err_q <= 1'b1;
      else if (err_clr_i) err_q <= 1'b0;
    end
  end

  // slot windows and bit index
  logic [CW-1:0] s_w, h_w, p_w, l_w, s2_w;
  logic          win1, win2, ws_raw;
  logic [4:0]    idx1, idx2;

  assign s_w  = CW'(slot);
  assign h_w  = (CW'(cfg_frame_m1_i) + CW'(1)) >> 1;
  assign p_w  = CW'(cfg_pos_i);
  assign l_w  = CW'(cfg_len_m1_i) + CW'(1);
  assign s2_w = s_w - h_w;
  assign ws_raw = (s_w >= h_w);
  assign win1 = (s_w > p_w) && (s_w <= p_w + l_w);
  assign win2 = ws_raw && (s2_w > p_w) && (s2_w <= p_w + l_w);
  assign idx1 = 5'(p_w + l_w - s_w);
  assign idx2 = 5'(p_w + l_w - s2_w);

  assign first_smp  = cfg_swap_i ? right_q : left_q;
  assign second_smp = cfg_swap_i ? left_q  : right_q;

  always_comb begin
    sd_o = 1'b0;
    if (run) begin
      if (win1)      sd_o = first_smp[idx1];
      else if (win2) sd_o = second_smp[idx2];
    end
  end

  assign sck_o      = phase ^ cfg_sck_inv_i;
  assign ws_o       = ws_raw ^ cfg_ws_inv_i;
  assign lvl_irq_o  = (fifo_level <= LVL_W'(cfg_wmark_i));
  assign underrun_o = err_q;
endmodule

// File: rtl/i2s_tx_serializer_chk.sv
module i2s_tx_serializer_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LVL_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             err_clr_i,
  input logic             cfg_sck_inv_i,
  input logic             sck_o,
  input logic             sd_o,
  input logic             full_o,
  input logic             lvl_irq_o,
  input logic             underrun_o,
  input logic             load_fire,
  input logic             pop_fire,
  input logic             err_set,
  input logic [LVL_W-1:0] fifo_level
);
  // R1
  level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_level <= LVL_W'(DEPTH));
  // R1
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !pop_fire) |=> full_o);
  // R9
  pop_at_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_fire |-> load_fire);
  // R10
  err_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underrun_o) |-> $past(err_set));
  // R11
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_clr_i && !err_set) |=> !underrun_o);
  // R12
  irq_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !lvl_irq_o);
  // R13
  idle_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!sd_o && (sck_o == cfg_sck_inv_i)));
endmodule

bind i2s_tx_serializer i2s_tx_serializer_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .en_i          (en_i),
  .err_clr_i     (err_clr_i),
  .cfg_sck_inv_i (cfg_sck_inv_i),
  .sck_o         (sck_o),
  .sd_o          (sd_o),
  .full_o        (full_o),
  .lvl_irq_o     (lvl_irq_o),
  .underrun_o    (underrun_o),
  .load_fire     (load_fire),
  .pop_fire      (pop_fire),
  .err_set       (err_set),
  .fifo_level    (fifo_level)
);

// File: tb/i2s_tx_serializer_bench.sv
module i2s_tx_serializer_bench;
  localparam int DEPTH = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic en = 0, wr = 0, wr_hi = 0, clr = 0;
  logic mono = 0, pack = 0, swap = 0, sinv = 0, winv = 0, zero = 0;
  logic [31:0] wdata = '0;
  logic [15:0] hdata = '0;
  logic [4:0]  len_m1 = 5'd15;
  logic [8:0]  fm1 = 9'd39, pos = '0;
  logic [7:0]  div = '0;
  logic [2:0]  wm = 3'd2;
  logic sck_o, ws_o, sd_o, lvl_irq_o, underrun_o, full_o;

  int total = 0, failed = 0, cyc = 0;
  bit chk_on = 0, hi_turn = 0;
  logic [31:0] pat = 32'h1234_5678;
  string tag = "R13";

  bit m_run = 0, m_phase = 0, m_err = 0;
  int m_div = 0, m_slot = 0;
  logic [31:0] ml = '0, mr = '0;
  logic [31:0] q[$];

  always #10 clk_i = ~clk_i;

  i2s_tx_serializer u_i2s_tx_serializer (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en), .wr_i(wr), .wr_data_i(wdata),
    .wr_hi_i(wr_hi), .wr_hi_data_i(hdata), .cfg_len_m1_i(len_m1),
    .cfg_frame_m1_i(fm1), .cfg_div_m1_i(div), .cfg_pos_i(pos),
    .cfg_mono_i(mono), .cfg_pack48_i(pack), .cfg_swap_i(swap),
    .cfg_sck_inv_i(sinv), .cfg_ws_inv_i(winv), .cfg_zero_fill_i(zero),
    .cfg_wmark_i(wm), .err_clr_i(clr), .sck_o(sck_o), .ws_o(ws_o),
    .sd_o(sd_o), .lvl_irq_o(lvl_irq_o), .underrun_o(underrun_o), .full_o(full_o));

  // behavioural reference, advanced on each rising edge
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_run = 0; m_phase = 0; m_err = 0; m_div = 0; m_slot = 0;
      ml = '0; mr = '0; q.delete();
    end else begin : model_step
      int sz, ln, need;
      bit fetch, under;
      logic [31:0] e0, e1;
      sz = q.size(); ln = int'(len_m1) + 1; under = 0; e1 = '0;
      fetch = en && (!m_run || (m_div == int'(div) && m_phase && m_slot >= int'(fm1)));
      if (fetch) begin
        need = (mono || ln <= 16) ? 1 : 2;
        if (sz >= need) begin
          e0 = q.pop_front();
          if (need == 2) e1 = q.pop_front();
          if (mono) begin ml = e0; mr = '0; end
          else if (ln <= 16) begin ml = {16'h0, e0[15:0]}; mr = {16'h0, e0[31:16]}; end
          else if (ln <= 24 && pack) begin ml = {8'h0, e0[23:0]}; mr = {8'h0, e1[15:0], e0[31:24]}; end
          else begin ml = e0; mr = e1; end
        end else begin
          under = 1;
          if (zero) begin ml = '0; mr = '0; end
        end
      end
      if (under) m_err = 1; else if (clr) m_err = 0;
      if ((wr || wr_hi) && sz < DEPTH) q.push_back(wr ? wdata : {16'h0, hdata});
      if (!en) begin m_run = 0; m_phase = 0; m_div = 0; m_slot = 0; end
      else if (!m_run) m_run = 1;
      else if (m_div == int'(div)) begin
        m_div = 0;
        if (m_phase) m_slot = (m_slot >= int'(fm1)) ? 0 : m_slot + 1;
        m_phase = !m_phase;
      end else m_div++;
    end
  end

  function automatic bit exp_sd();
    int h, p, ln, s2;
    logic [31:0] a, b;
    if (!m_run) return 1'b0;
    h = (int'(fm1) + 1) / 2; p = int'(pos); ln = int'(len_m1) + 1;
    a = swap ? mr : ml; b = swap ? ml : mr;
    if (m_slot > p && m_slot <= p + ln) return a[p + ln - m_slot];
    if (m_slot >= h) begin
      s2 = m_slot - h;
      if (s2 > p && s2 <= p + ln) return b[p + ln - s2];
    end
    return 1'b0;
  endfunction

  task automatic chk(input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", tag, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk_i) if (chk_on) begin
    chk(sck_o, m_phase ^ sinv, "R2 sck");
    chk(ws_o, (m_slot >= (int'(fm1) + 1) / 2) ^ winv, "R3 ws");
    chk(sd_o, exp_sd(), "R4 sd");
    chk(lvl_irq_o, q.size() <= int'(wm), "R12 irq");
    chk(underrun_o, m_err, "R10 underrun");
    chk(full_o, q.size() == DEPTH, "R1 full");
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      failed++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic drive_one(input bit alt);
    if (alt && hi_turn) begin wr_hi = 1; hdata = pat[15:0]; end
    else begin wr = 1; wdata = pat; end
    if (alt) hi_turn = !hi_turn;
    pat = pat * 32'd1103515245 + 32'd12345;
  endtask

  task automatic setup(input int l, input int f, input int p, input int d, input bit mo,
                       input bit pk, input bit sw, input bit si, input bit wi, input bit z);
    en = 0; wr = 0; wr_hi = 0; step();
    len_m1 = 5'(l - 1); fm1 = 9'(f - 1); pos = 9'(p); div = 8'(d - 1);
    mono = mo; pack = pk; swap = sw; sinv = si; winv = wi; zero = z;
    hi_turn = 0; step();
  endtask

  task automatic prefill(input int n, input bit alt);
    for (int i = 0; i < n; i++) begin
      wr = 0; wr_hi = 0; drive_one(alt); step();
    end
    wr = 0; wr_hi = 0; step();
  endtask

  task automatic run(input int clocks, input int every, input bit alt);
    en = 1;
    for (int c = 0; c < clocks; c++) begin
      wr = 0; wr_hi = 0;
      if (every > 0 && (c % every) == every - 1) drive_one(alt);
      step();
    end
    wr = 0; wr_hi = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1; chk_on = 1;
    @(negedge clk_i);
    tag = "R13";
    chk(sck_o, 1'b0, "R13 reset sck");
    chk(sd_o, 1'b0, "R13 reset sd");
    chk(full_o, 1'b0, "R13 reset full");
    chk(lvl_irq_o, 1'b1, "R12 reset irq on empty");
    chk(underrun_o, 1'b0, "R13 reset underrun");
    step();

    tag = "R5";  // 16-bit stereo, one entry per pair
    setup(16, 40, 0, 1, 0, 0, 0, 0, 0, 0);
    prefill(10, 0);
    @(negedge clk_i); chk(full_o, 1'b1, "R1 full after ten writes"); step();
    run(900, 70, 0);
    tag = "R5";  // 4-bit samples at bits 3:0 and 19:16
    setup(4, 16, 2, 2, 0, 0, 0, 0, 0, 0);
    prefill(4, 0); run(800, 50, 0);
    tag = "R5";  // 8-bit samples
    setup(8, 24, 3, 1, 0, 0, 0, 0, 0, 0);
    prefill(4, 0); run(600, 40, 0);
    tag = "R9";  // slower bit clock, fetch at frame ends
    setup(12, 32, 1, 3, 0, 0, 0, 0, 0, 0);
    prefill(3, 0); run(1200, 150, 0);
    tag = "R6";  // 24-bit unpacked
    setup(24, 60, 2, 1, 0, 0, 0, 0, 0, 0);
    prefill(8, 0); run(1200, 55, 0);
    tag = "R6";  // 24-bit packed pairs
    setup(24, 60, 2, 1, 0, 1, 0, 0, 0, 0);
    prefill(8, 1); run(1200, 55, 1);
    tag = "R6";  // 32-bit
    setup(32, 70, 1, 1, 0, 0, 0, 0, 0, 0);
    prefill(8, 0); run(1400, 65, 0);
    tag = "R7";  // mono, pack ignored
    setup(12, 32, 0, 1, 1, 1, 0, 0, 0, 0);
    prefill(6, 0); run(900, 60, 0);
    tag = "R8";  // swap with inverted clock and word select
    setup(16, 40, 2, 1, 0, 0, 1, 1, 1, 0);
    prefill(6, 0); run(900, 70, 0);
    tag = "R8";  // swapped mono
    setup(10, 30, 1, 1, 1, 0, 1, 0, 0, 0);
    prefill(6, 0); run(700, 55, 0);
    tag = "R12";
    wm = 3'd0; setup(16, 40, 0, 1, 0, 0, 0, 0, 0, 0);
    prefill(3, 0); wm = 3'd5; run(600, 0, 0);
    tag = "R10";  // drain to underrun, zeros sent
    setup(16, 40, 1, 1, 0, 0, 0, 0, 0, 1);
    run(1200, 0, 0);
    @(negedge clk_i); chk(underrun_o, 1'b1, "R10 underrun after drain"); step();
    tag = "R11";
    en = 0; step(); clr = 1; step(); clr = 0;
    @(negedge clk_i); chk(underrun_o, 1'b0, "R11 cleared by write one"); step();
    tag = "R10";  // stale repeat without zero fill
    setup(16, 40, 1, 1, 0, 0, 0, 0, 0, 0);
    prefill(1, 0); run(700, 0, 0);
    tag = "R11";  // clear held during running underruns
    clr = 1; run(300, 0, 0); clr = 0;
    tag = "R13";  // disable mid frame
    prefill(4, 0); run(130, 0, 0);
    en = 0; step();
    @(negedge clk_i);
    chk(sd_o, 1'b0, "R13 idle data");
    chk(sck_o, sinv, "R13 idle clock");
    step(); step();

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule